// File: doc/BRIEF.md
# Multi-Point Thermal Threshold Monitor

This block watches a group of three temperature sensing points. Each time a new set of 12-bit conversion results arrives, every enabled point is tested against a shared set of programmable limits: a hot limit, a cold limit, a pair of out-of-window offset limits and a hot-to-normal recovery limit. A condition raises an event only after it has held for a programmable run of consecutive samples. Events land in sticky status bits that software clears by writing ones. A single interrupt line is driven from those bits through a per-bit enable mask.

The same sample set also feeds a protection combiner. It reduces the enabled points to one value: their truncated average, their maximum or one chosen point. That value is held in a register, can be read back and is compared against three protection limits. A small word-addressed register port holds the limits, the control fields, the enable mask and the status. A separate input pulse reports a timeout of the external poll that collects the samples.

Top module: `thermal_thresh_mon`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq` is low and `prot_value` is zero. Word addresses: 0 control, 1 interrupt enable, 2 status, 3 hot limit, 4 cold limit, 5 hot-to-normal limit, 6 upper offset limit, 7 lower offset limit, 8/9/10 protection limits A/B/C, 11 protection value (read only).
- R2: For point p (data bits p*12 upward in `smp_data`), status bit 5p+0 flags value <= cold limit, 5p+1 value >= hot limit, 5p+2 value < lower offset limit, and 5p+3 value > upper offset limit.
- R3: The control field at bits 7:4 holds N. A condition raises its event on the (N+1)th consecutive qualifying sample of that point and on every qualifying sample after that. N = 0 means one sample is enough. A non-qualifying sample restarts the run.
- R4: Status bit 5p+4 (hot-to-normal) can fire only after point p has raised a hot event. After that, a sample below the hot-to-normal limit (debounced as in R3) sets it and re-arms the hysteresis, so a later sample below the limit sets nothing until another hot event occurs.
- R5: Status bits are sticky. Writing ones to address 2 clears the matching bits. An event arriving in the same cycle as its clear wins, and the bit stays set.
- R6: `irq` is high exactly when some status bit is set while its bit in the interrupt enable register is also set.
- R7: A pulse on `poll_timeout` sets status bit 15.
- R8: Status bit 16+p is set by every accepted sample of point p. Bit 19+p is set once for every M+1 accepted samples of point p, where M is the control field at bits 11:8.
- R9: Control bits 2:0 enable points 0 to 2. A disabled point raises no status bit, and its runs restart.
- R10: Control bits 17:16 choose the combiner. Value 0 gives the sum of the enabled points divided by their number, truncated, and 0 when no point is enabled.
- R11: Combiner value 1 gives the maximum of the enabled points. Values 2 and 3 give the point indexed by control bits 21:20, or 0 if that index is 3.
- R12: `prot_value` updates on the clock edge that accepts `smp_valid` and holds otherwise. It also reads at address 11. `prot_stage[k]` is high when `prot_value` >= protection limit k (k = 0, 1, 2 for A, B, C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: a new sample set is present |
| smp_data | input | 36 | Three 12-bit point results, point 0 in the low bits |
| poll_timeout | input | 1 | One-cycle pulse reporting a sampling poll timeout |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| prot_value | output | 12 | Registered protection combiner result |
| prot_stage | output | 3 | Protection limit comparisons A, B, C |

## Verification
Every status bit, `prot_value` and `prot_stage` is due after the single clock edge that accepts `smp_valid` or `poll_timeout`. `irq` and register reads follow with no further register stage. The bench therefore raises each strobe for exactly one cycle between falling edges and samples the ports one time unit after the next falling edge, when one rising edge has passed. Register writes use the same half-cycle pattern. A check of `irq` after an enable write or a clear is made at the falling edge after that write. Debounce runs and filter windows are counted in accepted samples, not in cycles, so these checks count `smp_valid` strobes.

// File: rtl/thm_pkg.sv
package thm_pkg;

    localparam int unsigned THM_NPTS     = 3;   // sensing points per group
    localparam int unsigned THM_CW       = 4;   // width of run and window counts
    localparam int unsigned THM_PT_FIELD = 5;   // status bits per point
    localparam int unsigned THM_STS_W    = 22;  // implemented status bits
    localparam int unsigned THM_BIT_TMO  = 15;
    localparam int unsigned THM_IMM_BASE = 16;
    localparam int unsigned THM_FLT_BASE = 19;
    localparam int unsigned THM_NPROT    = 3;   // protection limits

    // condition order inside one point field
    localparam int unsigned C_COLD = 0;
    localparam int unsigned C_HOT  = 1;
    localparam int unsigned C_LOW  = 2;
    localparam int unsigned C_HIGH = 3;
    localparam int unsigned C_H2N  = 4;

    typedef enum logic [1:0] {
        PM_AVG     = 2'd0,
        PM_MAX     = 2'd1,
        PM_SEL     = 2'd2,
        PM_SEL_ALT = 2'd3
    } prot_mode_e;

    typedef enum logic [3:0] {
        RA_CTRL  = 4'd0,
        RA_INTEN = 4'd1,
        RA_STS   = 4'd2,
        RA_HOT   = 4'd3,
        RA_COLD  = 4'd4,
        RA_H2N   = 4'd5,
        RA_OFFHI = 4'd6,
        RA_OFFLO = 4'd7,
        RA_PA    = 4'd8,
        RA_PB    = 4'd9,
        RA_PC    = 4'd10,
        RA_PVAL  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [1:0]          sel;
        prot_mode_e          mode;
        logic [THM_CW-1:0]   filt_len;
        logic [THM_CW-1:0]   evt_cnt;
        logic [THM_NPTS-1:0] pt_en;
    } mon_ctrl_t;

    function automatic int unsigned pt_bit(int unsigned sp, int unsigned kind);
        return sp * THM_PT_FIELD + kind;
    endfunction

endpackage

// File: rtl/thm_debounce.sv
module thm_debounce #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic          qual,
    input  logic [CW-1:0] limit,
    output logic          fire
);

    logic [CW-1:0] run_q;
    logic          reached;

    assign reached = (run_q >= limit);
    assign fire    = step && qual && reached;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (step) begin
            if (!qual) begin
                run_q <= '0;
            end else if (!reached) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R3: a zero count lets the first qualifying sample through
    p_single_sample_r3: assert property (@(posedge clk) disable iff (rst)
        (step && qual && !clear && limit == '0) |-> fire);

    // R3: a broken run leaves no event on the next sample unless count is zero
    p_run_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !qual && !clear) |=> ((fire && step && qual) |-> (limit == '0)));

endmodule

// File: rtl/thm_point.sv
module thm_point
    import thm_pkg::*;
#(
    parameter int unsigned DW = 12,
    parameter int unsigned CW = THM_CW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid,
    input  logic                    en,
    input  logic [DW-1:0]           value,
    input  logic [DW-1:0]           thr_hot,
    input  logic [DW-1:0]           thr_cold,
    input  logic [DW-1:0]           thr_h2n,
    input  logic [DW-1:0]           off_hi,
    input  logic [DW-1:0]           off_lo,
    input  logic [CW-1:0]           evt_cnt,
    input  logic [CW-1:0]           filt_len,
    output logic [THM_PT_FIELD-1:0] evt,
    output logic                    imm,
    output logic                    flt
);

    logic [THM_PT_FIELD-1:0] qual;
    logic                    hot_seen_q;
    logic [CW-1:0]           fcnt_q;
    logic                    accept;
    logic                    win_done;

    assign accept   = valid && en;
    assign win_done = (fcnt_q >= filt_len);

    always_comb begin
        qual         = '0;
        qual[C_COLD] = (value <= thr_cold);
        qual[C_HOT]  = (value >= thr_hot);
        qual[C_LOW]  = (value <  off_lo);
        qual[C_HIGH] = (value >  off_hi);
        qual[C_H2N]  = hot_seen_q && (value < thr_h2n);
    end

    for (genvar k = 0; k < THM_PT_FIELD; k++) begin : g_cond
        thm_debounce #(.CW(CW)) u_db (
            .clk   (clk),
            .rst   (rst),
            .clear (!en),
            .step  (accept),
            .qual  (qual[k]),
            .limit (evt_cnt),
            .fire  (evt[k])
        );
    end

    // hysteresis arm: set by a hot event, dropped by a hot-to-normal event
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hot_seen_q <= 1'b0;
        end else if (evt[C_HOT]) begin
            hot_seen_q <= 1'b1;
        end else if (evt[C_H2N]) begin
            hot_seen_q <= 1'b0;
        end
    end

    // filter window counted in accepted samples
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fcnt_q <= '0;
        end else if (accept) begin
            fcnt_q <= win_done ? '0 : fcnt_q + 1'b1;
        end
    end

    assign imm = accept;
    assign flt = accept && win_done;

    // R4: recovery event only while armed by an earlier hot event
    p_h2n_armed_r4: assert property (@(posedge clk) disable iff (rst)
        evt[C_H2N] |-> hot_seen_q);

    // R4: recovery disarms the point
    p_h2n_disarms_r4: assert property (@(posedge clk) disable iff (rst)
        (evt[C_H2N] && !evt[C_HOT]) |=> !hot_seen_q);

    // R9: a disabled point stays silent
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en |-> (evt == '0 && !imm && !flt));

endmodule

// File: rtl/thm_prot.sv
module thm_prot
    import thm_pkg::*;
#(
    parameter int unsigned DW = 12,
    parameter int unsigned NP = THM_NPTS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  valid,
    input  logic [NP-1:0]         en,
    input  logic [NP-1:0][DW-1:0] vals,
    input  prot_mode_e            mode,
    input  logic [1:0]            sel,
    output logic [DW-1:0]         prot_q
);

    localparam int unsigned SUMW = DW + $clog2(NP + 1);
    localparam int unsigned NW   = $clog2(NP + 1);

    logic [SUMW-1:0] sum;
    logic [NW-1:0]   n_en;
    logic [DW-1:0]   mx;
    logic [DW-1:0]   avg;
    logic [DW-1:0]   pick;
    logic [DW-1:0]   next_val;

    always_comb begin
        sum  = '0;
        n_en = '0;
        mx   = '0;
        for (int i = 0; i < NP; i++) begin
            if (en[i]) begin
                sum  = sum + SUMW'(vals[i]);
                n_en = n_en + 1'b1;
                if (vals[i] > mx) begin
                    mx = vals[i];
                end
            end
        end
    end

    assign avg  = (n_en == '0) ? '0 : DW'(sum / SUMW'(n_en));
    assign pick = (32'(sel) < NP) ? vals[sel] : '0;

    always_comb begin
        unique case (mode)
            PM_AVG:              next_val = avg;
            PM_MAX:              next_val = mx;
            PM_SEL, PM_SEL_ALT:  next_val = pick;
            default:             next_val = avg;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
        end else if (valid) begin
            prot_q <= next_val;
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_chk
        // R11: the maximum is not below any enabled point
        p_max_dominates_r11: assert property (@(posedge clk) disable iff (rst)
            (valid && mode == PM_MAX && en[i]) |=> (prot_q >= $past(vals[i])));
        // R10: the average is not above any... upper bound is the largest point
        p_avg_bounded_r10: assert property (@(posedge clk) disable iff (rst)
            (valid && mode == PM_AVG && en[i]) |=> (prot_q <= $past(mx)));
    end

endmodule

// File: rtl/thm_regs.sv
module thm_regs
    import thm_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [3:0]                     addr,
    input  logic [31:0]                    wdata,
    input  logic [THM_STS_W-1:0]           set_vec,
    input  logic [DW-1:0]                  prot_val,
    output mon_ctrl_t                      ctrl,
    output logic [DW-1:0]                  thr_hot,
    output logic [DW-1:0]                  thr_cold,
    output logic [DW-1:0]                  thr_h2n,
    output logic [DW-1:0]                  off_hi,
    output logic [DW-1:0]                  off_lo,
    output logic [THM_NPROT-1:0][DW-1:0]   prot_thr,
    output logic [31:0]                    rdata,
    output logic                           irq
);

    logic [THM_STS_W-1:0] int_en;
    logic [THM_STS_W-1:0] int_sts;
    logic [THM_STS_W-1:0] clr_vec;
    logic                 unused_wbits;

    assign unused_wbits = ^wdata[31:THM_STS_W];
    assign clr_vec = (we && addr == RA_STS) ? wdata[THM_STS_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            int_en   <= '0;
            thr_hot  <= '0;
            thr_cold <= '0;
            thr_h2n  <= '0;
            off_hi   <= '0;
            off_lo   <= '0;
            prot_thr <= '0;
        end else if (we) begin
            case (addr)
                RA_CTRL:  ctrl <= mon_ctrl_t'({wdata[21:20], wdata[17:16],
                                               wdata[11:8], wdata[7:4], wdata[2:0]});
                RA_INTEN: int_en      <= wdata[THM_STS_W-1:0];
                RA_HOT:   thr_hot     <= wdata[DW-1:0];
                RA_COLD:  thr_cold    <= wdata[DW-1:0];
                RA_H2N:   thr_h2n     <= wdata[DW-1:0];
                RA_OFFHI: off_hi      <= wdata[DW-1:0];
                RA_OFFLO: off_lo      <= wdata[DW-1:0];
                RA_PA:    prot_thr[0] <= wdata[DW-1:0];
                RA_PB:    prot_thr[1] <= wdata[DW-1:0];
                RA_PC:    prot_thr[2] <= wdata[DW-1:0];
                default:  ;
            endcase
        end
    end

    // sticky status: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            int_sts <= '0;
        end else begin
            int_sts <= (int_sts & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(int_sts & int_en);

    always_comb begin
        case (addr)
            RA_CTRL:  rdata = {10'b0, ctrl.sel, 2'b0, ctrl.mode, 4'b0,
                               ctrl.filt_len, ctrl.evt_cnt, 1'b0, ctrl.pt_en};
            RA_INTEN: rdata = 32'(int_en);
            RA_STS:   rdata = 32'(int_sts);
            RA_HOT:   rdata = 32'(thr_hot);
            RA_COLD:  rdata = 32'(thr_cold);
            RA_H2N:   rdata = 32'(thr_h2n);
            RA_OFFHI: rdata = 32'(off_hi);
            RA_OFFLO: rdata = 32'(off_lo);
            RA_PA:    rdata = 32'(prot_thr[0]);
            RA_PB:    rdata = 32'(prot_thr[1]);
            RA_PC:    rdata = 32'(prot_thr[2]);
            RA_PVAL:  rdata = 32'(prot_val);
            default:  rdata = '0;
        endcase
    end

    // R5: a set bit survives unless a clear for it was written
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(int_sts) & ~$past(clr_vec) & ~int_sts) == '0));

    // R5: a cleared bit with no competing event reads zero afterwards
    p_clear_works_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((int_sts & $past(clr_vec & ~set_vec)) == '0));

    // R6: nothing enabled means no request
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (int_en == '0) |-> !irq);

    // R7: a timeout pulse is recorded
    p_timeout_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_vec[THM_BIT_TMO] |=> int_sts[THM_BIT_TMO]);

endmodule

// File: rtl/thermal_thresh_mon.sv
module thermal_thresh_mon
    import thm_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic [THM_NPTS*DW-1:0]   smp_data,
    input  logic                     poll_timeout,
    input  logic                     reg_we,
    input  logic [3:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     irq,
    output logic [DW-1:0]            prot_value,
    output logic [THM_NPROT-1:0]     prot_stage
);

    mon_ctrl_t                        ctrl;
    logic [DW-1:0]                    thr_hot, thr_cold, thr_h2n, off_hi, off_lo;
    logic [THM_NPROT-1:0][DW-1:0]     prot_thr;
    logic [THM_STS_W-1:0]             set_vec;
    logic [THM_NPTS-1:0][THM_PT_FIELD-1:0] evt_v;
    logic [THM_NPTS-1:0]              imm_v;
    logic [THM_NPTS-1:0]              flt_v;
    logic [THM_NPTS-1:0][DW-1:0]      pt_val;

    thm_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_vec  (set_vec),
        .prot_val (prot_value),
        .ctrl     (ctrl),
        .thr_hot  (thr_hot),
        .thr_cold (thr_cold),
        .thr_h2n  (thr_h2n),
        .off_hi   (off_hi),
        .off_lo   (off_lo),
        .prot_thr (prot_thr),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    for (genvar sp = 0; sp < THM_NPTS; sp++) begin : g_pt
        assign pt_val[sp] = smp_data[sp*DW +: DW];

        thm_point #(.DW(DW), .CW(THM_CW)) u_pt (
            .clk      (clk),
            .rst      (rst),
            .valid    (smp_valid),
            .en       (ctrl.pt_en[sp]),
            .value    (pt_val[sp]),
            .thr_hot  (thr_hot),
            .thr_cold (thr_cold),
            .thr_h2n  (thr_h2n),
            .off_hi   (off_hi),
            .off_lo   (off_lo),
            .evt_cnt  (ctrl.evt_cnt),
            .filt_len (ctrl.filt_len),
            .evt      (evt_v[sp]),
            .imm      (imm_v[sp]),
            .flt      (flt_v[sp])
        );
    end

    always_comb begin
        set_vec = '0;
        for (int sp = 0; sp < THM_NPTS; sp++) begin
            set_vec[pt_bit(sp, 0) +: THM_PT_FIELD] = evt_v[sp];
            set_vec[THM_IMM_BASE + sp]             = imm_v[sp];
            set_vec[THM_FLT_BASE + sp]             = flt_v[sp];
        end
        set_vec[THM_BIT_TMO] = poll_timeout;
    end

    thm_prot #(.DW(DW), .NP(THM_NPTS)) u_prot (
        .clk    (clk),
        .rst    (rst),
        .valid  (smp_valid),
        .en     (ctrl.pt_en),
        .vals   (pt_val),
        .mode   (ctrl.mode),
        .sel    (ctrl.sel),
        .prot_q (prot_value)
    );

    for (genvar k = 0; k < THM_NPROT; k++) begin : g_stage
        assign prot_stage[k] = (prot_value >= prot_thr[k]);
    end

    // R12: the protection value moves only on an accepted sample set
    p_prot_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(prot_value));

endmodule

// File: tb/sim_thermal_thresh_mon.sv
module sim_thermal_thresh_mon;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [35:0] smp_data = '0;
    logic        poll_timeout = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [11:0] prot_value;
    logic [2:0]  prot_stage;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thermal_thresh_mon u0 (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .poll_timeout (poll_timeout),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq          (irq),
        .prot_value   (prot_value),
        .prot_stage   (prot_stage)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    function automatic int cfg(int en, int ev, int fl, int md, int sl);
        return (sl << 20) | (md << 16) | (fl << 8) | (ev << 4) | en;
    endfunction

    function automatic int fld(int sts, int sp);
        return (sts >> (sp * 5)) & 31;
    endfunction

    task automatic smp(input int a, input int b, input int c);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = {12'(c), 12'(b), 12'(a)};
        @(negedge clk);
        smp_valid = 1'b0;
        #1;
    endtask

    task automatic clear_all();
        wr(2, 32'h3F_FFFF);
    endtask

    task automatic t_reset();
        int d;
        rd(0, d);  chk("R1 ctrl reset", d, 0);
        rd(2, d);  chk("R1 status reset", d, 0);
        rd(3, d);  chk("R1 hot limit reset", d, 0);
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 prot reset", int'(prot_value), 0);
    endtask

    task automatic t_compare();
        int d;
        wr(3, 3000); wr(4, 500); wr(5, 2000); wr(6, 2500); wr(7, 800);
        wr(0, cfg(7, 0, 0, 0, 0));
        clear_all();
        smp(400, 2600, 1000);
        rd(2, d);
        chk("R2 p0 cold+low", fld(d, 0), 5);
        chk("R2 p1 high offset", fld(d, 1), 8);
        chk("R2 p2 none", fld(d, 2), 0);
        clear_all();
        smp(3000, 500, 2500);
        rd(2, d);
        chk("R2 p0 hot at limit + high", fld(d, 0), 10);
        chk("R2 p1 cold at limit + low", fld(d, 1), 5);
        chk("R2 p2 upper limit not exceeded", fld(d, 2), 0);
    endtask

    task automatic t_debounce();
        int d;
        wr(0, cfg(7, 2, 0, 0, 0));
        smp(1000, 1000, 1000);
        clear_all();
        smp(3100, 1000, 1000); rd(2, d); chk("R3 run 1 of 3", (d >> 1) & 1, 0);
        smp(3100, 1000, 1000); rd(2, d); chk("R3 run 2 of 3", (d >> 1) & 1, 0);
        smp(3100, 1000, 1000); rd(2, d); chk("R3 run 3 of 3", (d >> 1) & 1, 1);
        smp(1000, 1000, 1000);
        clear_all();
        smp(3100, 1000, 1000); smp(3100, 1000, 1000);
        smp(1000, 1000, 1000);
        smp(3100, 1000, 1000); smp(3100, 1000, 1000);
        rd(2, d); chk("R3 broken run", (d >> 1) & 1, 0);
        smp(3100, 1000, 1000);
        rd(2, d); chk("R3 restarted run completes", (d >> 1) & 1, 1);
    endtask

    task automatic t_h2n();
        int d;
        wr(0, cfg(7, 0, 0, 0, 0));
        clear_all();
        smp(1000, 1500, 1000);
        rd(2, d); chk("R4 no recovery before hot", (d >> 9) & 1, 0);
        smp(1000, 3200, 1000);
        rd(2, d); chk("R4 p1 hot", (d >> 6) & 1, 1);
        smp(1000, 1500, 1000);
        rd(2, d); chk("R4 recovery after hot", (d >> 9) & 1, 1);
        clear_all();
        smp(1000, 1500, 1000);
        rd(2, d); chk("R4 disarmed after recovery", (d >> 9) & 1, 0);
    endtask

    task automatic t_irq();
        int d;
        wr(1, 0);
        clear_all();
        smp(3100, 1000, 1000);
        rd(2, d); chk("R6 status set", (d >> 1) & 1, 1);
        chk("R6 masked irq low", int'(irq), 0);
        wr(1, 2);
        chk("R6 enabled irq high", int'(irq), 1);
        wr(2, 2);
        chk("R6 irq drops after clear", int'(irq), 0);
        wr(1, 0);
    endtask

    task automatic t_timeout();
        int d;
        clear_all();
        @(negedge clk); poll_timeout = 1'b1;
        @(negedge clk); poll_timeout = 1'b0;
        #1;
        rd(2, d); chk("R7 timeout bit", (d >> 15) & 1, 1);
    endtask

    task automatic t_w1c();
        int d;
        wr(0, cfg(7, 0, 0, 0, 0));
        clear_all();
        smp(1000, 1000, 1000);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = {12'd1000, 12'd1000, 12'd1000};
        reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h1_0000;
        @(negedge clk);
        smp_valid = 1'b0; reg_we = 1'b0;
        #1;
        rd(2, d); chk("R5 event outranks clear", (d >> 16) & 1, 1);
        wr(2, 32'h1_0000);
        rd(2, d);
        chk("R5 cleared bit", (d >> 16) & 1, 0);
        chk("R5 other bit sticky", (d >> 17) & 1, 1);
    endtask

    task automatic t_filter();
        int d;
        wr(0, cfg(7, 0, 1, 0, 0));
        clear_all();
        smp(1000, 1000, 1000);
        rd(2, d);
        chk("R8 immediate bits", (d >> 16) & 7, 7);
        chk("R8 window not done", (d >> 19) & 7, 0);
        smp(1000, 1000, 1000);
        rd(2, d); chk("R8 window done", (d >> 19) & 7, 7);
        clear_all();
        smp(1000, 1000, 1000);
        rd(2, d); chk("R8 window restarted", (d >> 19) & 7, 0);
    endtask

    task automatic t_disabled();
        int d;
        wr(0, cfg(5, 0, 0, 0, 0));
        clear_all();
        smp(1000, 3500, 1000);
        rd(2, d);
        chk("R9 disabled point no hot", (d >> 6) & 1, 0);
        chk("R9 disabled point no sense", (d >> 17) & 1, 0);
        chk("R9 enabled point sense", (d >> 16) & 1, 1);
    endtask

    task automatic t_prot();
        int d;
        wr(8, 150); wr(9, 300); wr(10, 1000);
        wr(0, cfg(7, 0, 0, 0, 0));
        smp(100, 200, 400);
        chk("R10 average of three", int'(prot_value), 233);
        rd(11, d); chk("R12 readback", d, 233);
        wr(0, cfg(5, 0, 0, 0, 0));
        smp(100, 200, 400);
        chk("R10 average of enabled", int'(prot_value), 250);
        chk("R12 stage at 250", int'(prot_stage), 1);
        wr(0, cfg(0, 0, 0, 0, 0));
        smp(100, 200, 400);
        chk("R10 none enabled", int'(prot_value), 0);
        wr(0, cfg(7, 0, 0, 1, 0));
        smp(100, 900, 400);
        chk("R11 max", int'(prot_value), 900);
        wr(0, cfg(5, 0, 0, 1, 0));
        smp(100, 900, 400);
        chk("R11 max of enabled", int'(prot_value), 400);
        wr(0, cfg(7, 0, 0, 2, 1));
        smp(100, 300, 400);
        chk("R11 selected point", int'(prot_value), 300);
        chk("R12 stage at limit", int'(prot_stage), 3);
        repeat (3) @(negedge clk);
        #1;
        chk("R12 holds without sample", int'(prot_value), 300);
        wr(0, cfg(7, 0, 0, 3, 2));
        smp(100, 300, 1400);
        chk("R11 mode 3 selects", int'(prot_value), 1400);
        chk("R12 all stages", int'(prot_stage), 7);
        wr(0, cfg(7, 0, 0, 2, 3));
        smp(100, 300, 1400);
        chk("R11 index 3 gives zero", int'(prot_value), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_compare();
        t_debounce();
        t_h2n();
        t_irq();
        t_timeout();
        t_w1c();
        t_filter();
        t_disabled();
        t_prot();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule